// File: doc/BRIEF.md
# Chained Key Event Relay Node

This block is one link in a chain of serial nodes that carry key-matrix activity toward a controller. All nodes share a bit clock driven by the controller. Each node takes in a serial stream from its upstream neighbour and drives a serial stream toward the controller. Traffic is framed in 8-clock byte slots, counted from the release of reset. A message is two bytes: a tag byte with its top bit set, then a hop count. The node passes every message on. It keeps the tag as it is and adds one to the hop count, so the controller can work out from the count how far away the event started.

Each node also watches two active-low contacts of its own: a key contact and a velocity contact. Both are synchronized into the clock domain, and edges are detected against a stored copy of the last accepted level. Each edge becomes a new message with a hop count of one. That message waits in a two-entry event queue until it can enter the output byte queue at a slot boundary. It is placed there only behind relay bytes that are already queued, and never between the two bytes of a relay message. Slots with nothing to send go out as all zeros, which downstream nodes drop.

Top module: `relay_node`

## Requirements
- R1: While reset is asserted, and in every slot for which nothing is queued, the serial output is held low, so an idle slot carries the byte 0x00.
- R2: Slots are 8 clocks long and bytes travel MSB first. The input is sampled on rising clock edges. Releasing the reset takes two rising edges, and the first slot's MSB is sampled on the third rising edge after release.
- R3: A byte whose bit 7 is 1, received while a tag byte is expected, is forwarded unchanged. The byte received next is taken as a hop count whatever its value, and after that count a tag byte is expected again.
- R4: A forwarded hop count equals the received count plus one, modulo 256, so 255 becomes 0.
- R5: A byte whose bit 7 is 0, received while a tag byte is expected, is discarded and nothing is sent for it.
- R6: When the output queue is empty, a byte received in slot n goes out in slot n+2.
- R7: A level change on the key contact yields the tag 0xA0 on a falling level (press) and 0x80 on a rising level (release). A level change on the velocity contact yields 0xE0 (press) or 0xC0 (release). Each such tag is followed by the count 0x01.
- R8: When both contacts change in the same cycle, the key message is sent first and the velocity message follows it at once.
- R9: A local message is never placed between the two bytes of a relay message. It goes out after the relay bytes already queued, relay messages keep their order, and the output queue never holds more than its depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared bit clock from the controller |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_in | input | 1 | Serial stream from the upstream neighbour, MSB first |
| key_n | input | 1 | Key contact, low when closed |
| vel_n | input | 1 | Velocity contact, low when closed |
| ser_out | output | 1 | Serial stream toward the controller, MSB first |

## Verification
On every cycle, the assertions check the parser's alternation between tag and count, the dropping of untagged bytes, the low output in idle slots, and the limits on the event and output queues. Some behaviours only the bench scenarios can show. These are the exact two-slot relay latency, the count arithmetic across all 256 values, the tag values produced for each contact edge, and the ordering when both contacts change at once. They also include where a local message lands inside back-to-back relay traffic without splitting any relay message.

// File: rtl/relay_pkg.sv
package relay_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic is_vel;
    logic press;
  } evt_t;

  localparam byte_t ORIGIN_COUNT = 8'd1;

  function automatic byte_t make_tag(evt_t e);
    return {1'b1, e.is_vel, e.press, 5'b00000};
  endfunction
endpackage

// File: rtl/relay_sync.sv
module relay_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '1;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/relay_rx.sv
module relay_rx
  import relay_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ser_in,
  output logic  slot_end,
  output byte_t rx_byte,
  output logic  expect_cnt,
  output logic  relay_vld,
  output byte_t relay_byte,
  output logic  mid_msg
);
  logic [BIT_CNT_W-1:0] bit_cnt, bit_cnt_nxt;
  byte_t                sh, sh_nxt;
  logic                 exp_nxt;

  assign slot_end = (bit_cnt == BIT_CNT_W'(BYTE_W - 1));
  assign rx_byte  = {sh[BYTE_W-2:0], ser_in};

  always_comb begin
    bit_cnt_nxt = bit_cnt + BIT_CNT_W'(1);
    sh_nxt      = rx_byte;
    exp_nxt     = expect_cnt;
    relay_vld   = 1'b0;
    relay_byte  = rx_byte;
    if (slot_end) begin
      if (expect_cnt) begin
        relay_vld  = 1'b1;
        relay_byte = rx_byte + 8'd1;
        exp_nxt    = 1'b0;
      end else if (rx_byte[BYTE_W-1]) begin
        relay_vld  = 1'b1;
        exp_nxt    = 1'b1;
      end else begin
        exp_nxt    = 1'b0;
      end
    end
  end

  assign mid_msg = exp_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      sh         <= '0;
      expect_cnt <= 1'b0;
    end else begin
      bit_cnt <= bit_cnt_nxt;
      sh      <= sh_nxt;
      if (slot_end) expect_cnt <= exp_nxt;
    end
  end
endmodule

// File: rtl/relay_evq.sv
module relay_evq
  import relay_pkg::*;
#(
  parameter int  EQ_DEPTH = 2,
  localparam int ECW      = $clog2(EQ_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           key_s,
  input  logic           vel_s,
  input  logic           pop,
  output logic           ev_vld,
  output evt_t           ev_head,
  output logic [ECW-1:0] ev_cnt
);
  evt_t           mem     [EQ_DEPTH];
  evt_t           mem_nxt [EQ_DEPTH];
  logic [ECW-1:0] cnt_nxt;
  logic           key_last, vel_last, key_last_nxt, vel_last_nxt;
  logic           take_key, take_vel;
  int             n, k;

  always_comb begin
    mem_nxt  = mem;
    n        = int'(ev_cnt);
    take_key = (key_s ^ key_last) && (int'(ev_cnt) < EQ_DEPTH);
    take_vel = (vel_s ^ vel_last) && ((int'(ev_cnt) + (take_key ? 1 : 0)) < EQ_DEPTH);
    if (pop && (ev_cnt != '0)) begin
      for (int i = 0; i < EQ_DEPTH - 1; i++) mem_nxt[i] = mem[i+1];
      mem_nxt[EQ_DEPTH-1] = '0;
      n = n - 1;
    end
    for (int i = 0; i < EQ_DEPTH; i++) begin
      if (take_key && (i == n)) mem_nxt[i] = '{is_vel: 1'b0, press: ~key_s};
    end
    k = n + (take_key ? 1 : 0);
    for (int i = 0; i < EQ_DEPTH; i++) begin
      if (take_vel && (i == k)) mem_nxt[i] = '{is_vel: 1'b1, press: ~vel_s};
    end
    cnt_nxt      = ECW'(k + (take_vel ? 1 : 0));
    key_last_nxt = take_key ? key_s : key_last;
    vel_last_nxt = take_vel ? vel_s : vel_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem      <= '{default: '0};
      ev_cnt   <= '0;
      key_last <= 1'b1;
      vel_last <= 1'b1;
    end else begin
      mem      <= mem_nxt;
      ev_cnt   <= cnt_nxt;
      key_last <= key_last_nxt;
      vel_last <= vel_last_nxt;
    end
  end

  assign ev_vld  = (ev_cnt != '0);
  assign ev_head = mem[0];
endmodule

// File: rtl/relay_txq.sv
module relay_txq
  import relay_pkg::*;
#(
  parameter int  OQ_DEPTH = 4,
  localparam int QCW      = $clog2(OQ_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slot_end,
  input  logic           relay_vld,
  input  byte_t          relay_byte,
  input  logic           mid_msg,
  input  logic           ev_vld,
  input  evt_t           ev_head,
  output logic           ev_pop,
  output logic [QCW-1:0] q_cnt,
  output logic           ser_out
);
  byte_t          q_mem     [OQ_DEPTH];
  byte_t          q_mem_nxt [OQ_DEPTH];
  logic [QCW-1:0] q_cnt_nxt;
  byte_t          tx_sh, tx_sh_nxt;
  logic           do_pop;
  int             wr, r;

  always_comb begin
    q_mem_nxt = q_mem;
    q_cnt_nxt = q_cnt;
    tx_sh_nxt = {tx_sh[BYTE_W-2:0], 1'b0};
    do_pop    = slot_end && (q_cnt != '0);
    wr        = int'(q_cnt) - (do_pop ? 1 : 0);
    r         = (slot_end && relay_vld) ? 1 : 0;
    ev_pop    = slot_end && ev_vld && !mid_msg && ((wr + r + 2) <= OQ_DEPTH);
    if (slot_end) begin
      tx_sh_nxt = do_pop ? q_mem[0] : '0;
      if (do_pop) begin
        for (int i = 0; i < OQ_DEPTH - 1; i++) q_mem_nxt[i] = q_mem[i+1];
        q_mem_nxt[OQ_DEPTH-1] = '0;
      end
      for (int i = 0; i < OQ_DEPTH; i++) begin
        if ((r == 1) && (i == wr))          q_mem_nxt[i] = relay_byte;
        if (ev_pop && (i == wr + r))        q_mem_nxt[i] = make_tag(ev_head);
        if (ev_pop && (i == wr + r + 1))    q_mem_nxt[i] = ORIGIN_COUNT;
      end
      q_cnt_nxt = QCW'(wr + r + (ev_pop ? 2 : 0));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_mem <= '{default: '0};
      q_cnt <= '0;
      tx_sh <= '0;
    end else begin
      tx_sh <= tx_sh_nxt;
      if (slot_end) begin
        q_mem <= q_mem_nxt;
        q_cnt <= q_cnt_nxt;
      end
    end
  end

  assign ser_out = tx_sh[BYTE_W-1];
endmodule

// File: rtl/relay_node.sv
module relay_node
  import relay_pkg::*;
#(
  parameter int OQ_DEPTH    = 4,
  parameter int EQ_DEPTH    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  input  logic key_n,
  input  logic vel_n,
  output logic ser_out
);
  localparam int QCW = $clog2(OQ_DEPTH + 1);
  localparam int ECW = $clog2(EQ_DEPTH + 1);

  logic [1:0]     rst_pipe;
  logic           rst_int_n;
  logic [1:0]     sw_s;
  logic           slot_end, expect_cnt, relay_vld, mid_msg;
  byte_t          rx_byte, relay_byte;
  logic           ev_vld, ev_pop;
  evt_t           ev_head;
  logic [ECW-1:0] ev_cnt;
  logic [QCW-1:0] q_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  relay_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .din({key_n, vel_n}), .dout(sw_s)
  );

  relay_rx u_rx (
    .clk(clk), .rst_n(rst_int_n), .ser_in(ser_in),
    .slot_end(slot_end), .rx_byte(rx_byte), .expect_cnt(expect_cnt),
    .relay_vld(relay_vld), .relay_byte(relay_byte), .mid_msg(mid_msg)
  );

  relay_evq #(.EQ_DEPTH(EQ_DEPTH)) u_evq (
    .clk(clk), .rst_n(rst_int_n), .key_s(sw_s[1]), .vel_s(sw_s[0]),
    .pop(ev_pop), .ev_vld(ev_vld), .ev_head(ev_head), .ev_cnt(ev_cnt)
  );

  relay_txq #(.OQ_DEPTH(OQ_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_int_n), .slot_end(slot_end),
    .relay_vld(relay_vld), .relay_byte(relay_byte), .mid_msg(mid_msg),
    .ev_vld(ev_vld), .ev_head(ev_head), .ev_pop(ev_pop),
    .q_cnt(q_cnt), .ser_out(ser_out)
  );
endmodule

// File: rtl/relay_node_chk.sv
module relay_node_chk #(
  parameter int OQ_DEPTH = 4,
  parameter int EQ_DEPTH = 2
) (
  input logic                               clk,
  input logic                               rst_int_n,
  input logic                               slot_end,
  input logic                               expect_cnt,
  input logic [7:0]                         rx_byte,
  input logic                               ev_pop,
  input logic [$clog2(OQ_DEPTH+1)-1:0]      q_cnt,
  input logic [$clog2(EQ_DEPTH+1)-1:0]      ev_cnt,
  input logic                               ser_out
);
  localparam int QCW = $clog2(OQ_DEPTH + 1);
  logic [QCW-1:0] q_after_pop;
  assign q_after_pop = (q_cnt != '0) ? (q_cnt - QCW'(1)) : q_cnt;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (slot_end && (q_cnt == '0)) |=> !ser_out); // R1

  AST_TAG_THEN_COUNT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (slot_end && !expect_cnt && rx_byte[7]) |=> expect_cnt); // R3

  AST_COUNT_THEN_TAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    (slot_end && expect_cnt) |=> !expect_cnt); // R3

  AST_JUNK_DROPPED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (slot_end && !expect_cnt && !rx_byte[7] && !ev_pop) |=> (q_cnt == $past(q_after_pop))); // R5

  AST_EVQ_BOUND: assert property (@(posedge clk) disable iff (!rst_int_n)
    int'(ev_cnt) <= EQ_DEPTH); // R8

  AST_OQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    int'(q_cnt) <= OQ_DEPTH); // R9

  AST_INJECT_PAIR: assert property (@(posedge clk) disable iff (!rst_int_n)
    ev_pop |=> (int'(q_cnt) >= 2)); // R9
endmodule

bind relay_node relay_node_chk #(.OQ_DEPTH(OQ_DEPTH), .EQ_DEPTH(EQ_DEPTH)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .slot_end(slot_end), .expect_cnt(expect_cnt),
  .rx_byte(rx_byte), .ev_pop(ev_pop), .q_cnt(q_cnt), .ev_cnt(ev_cnt), .ser_out(ser_out)
);

// File: tb/relay_node_tb.sv
module relay_node_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0;
  logic key_n = 1'b1;
  logic vel_n = 1'b1;
  logic ser_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] got_t[$], got_c[$], exp_t[$], exp_c[$];
  bit         mon_have = 0;
  logic [7:0] mon_t;
  logic [7:0] o;

  always #5 clk = ~clk;

  relay_node u_dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
    .key_n(key_n), .vel_n(vel_n), .ser_out(ser_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mon(input logic [7:0] b);
    if (mon_have) begin
      got_t.push_back(mon_t);
      got_c.push_back(b);
      mon_have = 0;
    end else if (b[7]) begin
      mon_t = b;
      mon_have = 1;
    end
  endtask

  task automatic do_slot(input logic [7:0] b, output logic [7:0] ob);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ob[7-i] = ser_out;
      ser_in  = b[7-i];
    end
    mon(ob);
  endtask

  task automatic idle(input int n);
    logic [7:0] t;
    for (int i = 0; i < n; i++) do_slot(8'h00, t);
  endtask

  task automatic compare(input string req);
    chk(got_t.size() == exp_t.size(), req, got_t.size(), exp_t.size());
    if (got_t.size() == exp_t.size()) begin
      for (int i = 0; i < exp_t.size(); i++) begin
        chk(got_t[i] == exp_t[i], req, got_t[i], exp_t[i]);
        chk(got_c[i] == exp_c[i], req, got_c[i], exp_c[i]);
      end
    end
    got_t.delete(); got_c.delete(); exp_t.delete(); exp_c.delete();
  endtask

  task automatic expect_msg(input logic [7:0] t, input logic [7:0] c);
    exp_t.push_back(t);
    exp_c.push_back(c);
  endtask

  initial begin
    logic [7:0] tg;
    bit zero_ok;
    int found;
    int idx;
    // R1: output low during reset
    repeat (3) @(negedge clk);
    chk(ser_out == 1'b0, "R1 reset", ser_out, 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    // R1 / R2: idle slots after release are zero
    for (int i = 0; i < 3; i++) begin
      do_slot(8'h00, o);
      chk(o == 8'h00, "R1 idle slot", o, 0);
    end
    // R6 / R2: latency of two slots, R4 increment
    do_slot(8'hA0, o);
    chk(o == 8'h00, "R6 slot n", o, 0);
    do_slot(8'h05, o);
    chk(o == 8'h00, "R6 slot n+1", o, 0);
    do_slot(8'h00, o);
    chk(o == 8'hA0, "R6 R2 tag in slot n+2", o, 8'hA0);
    do_slot(8'h00, o);
    chk(o == 8'h06, "R4 count in slot n+3", o, 8'h06);
    idle(2);
    got_t.delete(); got_c.delete();
    // R3 / R4: sweep of all counts, back to back
    for (int c = 0; c < 256; c++) begin
      tg = 8'h80 | 8'((c * 37) & 8'h7F);
      do_slot(tg, o);
      do_slot(8'(c), o);
      expect_msg(tg, 8'((c + 1) & 255));
    end
    idle(4);
    compare("R3 R4 sweep");
    // R5: every untagged byte is dropped
    zero_ok = 1;
    for (int b = 0; b < 128; b++) begin
      do_slot(8'(b), o);
      if (o != 8'h00) zero_ok = 0;
    end
    idle(3);
    chk(zero_ok, "R5 junk output", zero_ok, 1);
    compare("R5 junk");
    // R3: count byte with bit 7 set, then parser returns to tag state
    do_slot(8'h80, o);
    do_slot(8'h90, o);
    do_slot(8'h05, o);
    idle(4);
    expect_msg(8'h80, 8'h91);
    compare("R3 count with top bit");
    // R7: local events
    key_n = 1'b0; idle(6); expect_msg(8'hA0, 8'h01); compare("R7 key press");
    key_n = 1'b1; idle(6); expect_msg(8'h80, 8'h01); compare("R7 key release");
    vel_n = 1'b0; idle(6); expect_msg(8'hE0, 8'h01); compare("R7 vel press");
    vel_n = 1'b1; idle(6); expect_msg(8'hC0, 8'h01); compare("R7 vel release");
    // R8: simultaneous changes
    key_n = 1'b0; vel_n = 1'b0; idle(8);
    expect_msg(8'hA0, 8'h01); expect_msg(8'hE0, 8'h01); compare("R8 both press");
    key_n = 1'b1; vel_n = 1'b1; idle(8);
    expect_msg(8'h80, 8'h01); expect_msg(8'hC0, 8'h01); compare("R8 both release");
    // R9: local event inside sustained relay traffic
    for (int k = 0; k < 20; k++) begin
      if (k == 5) vel_n = 1'b0;
      do_slot(8'h80, o);
      do_slot(8'(k + 10), o);
    end
    idle(8);
    chk(got_t.size() == 21, "R9 message total", got_t.size(), 21);
    found = 0;
    idx = 0;
    for (int i = 0; i < got_t.size(); i++) begin
      if (got_t[i] == 8'hE0 && got_c[i] == 8'h01) found++;
      else begin
        chk(got_t[i] == 8'h80, "R9 relay tag order", got_t[i], 8'h80);
        chk(got_c[i] == 8'(idx + 11), "R9 relay count order", got_c[i], idx + 11);
        idx++;
      end
    end
    chk(found == 1, "R9 local inserted once", found, 1);
    got_t.delete(); got_c.delete();
    vel_n = 1'b1; idle(6);
    expect_msg(8'hC0, 8'h01); compare("R7 R9 vel release after traffic");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule